// File: doc/BRIEF.md
# Audio Transceiver Busy-Status Tracker

This block keeps the four activity flags of a biphase-coded digital audio transmitter and receiver: transmit shifter active, receive shifter active, channel-status word shifting, and transmit user-data queue draining. The block does no coding or shifting itself. Framing and queue events reach it as single-cycle strobes or levels from the neighbouring datapath, and it turns them into four registered busy bits that control software or a power manager can poll.

Removing an enable does not drop its flag at once. The flag is held until the next frame boundary, so that a shifter is never reported idle while it is still inside a frame. Each tracker has a second, immediate release source of its own: the incoming stream going quiet, the last channel-status word being loaded, or the user queue running dry. All trackers share one next-state function. A small decoder builds each tracker's set, release and gating terms from the raw inputs.

Top module: `xcvr_busy_tracker`

## Requirements
- R1: After a synchronous reset all four busy outputs are 0.
- R2: `tx_busy` is 1 in the cycle after any cycle in which `tx_on` is 1.
- R3: Once `tx_on` goes low, `tx_busy` stays 1 until a `frame_end` pulse arrives in a later cycle. It is 0 in the cycle after that pulse. A `frame_end` pulse in the same cycle that `tx_on` falls does not release the flag.
- R4: If the enable is high again in or before the cycle of the pending `frame_end`, the release is cancelled and the flag stays 1.
- R5: `rx_busy` becomes 1 in the cycle after `rx_lock` while `rx_on` is 1. `rx_lock` while `rx_on` is 0 has no effect.
- R6: `rx_busy` is 0 in the cycle after `rx_idle` is 1. This takes priority over an `rx_lock` in the same cycle. After `rx_on` falls, `rx_busy` is also released by the next later `frame_end`.
- R7: `cs_busy` becomes 1 in the cycle after `cs_load` with `cs_word` = 0 while both `tx_on` and `cs_on` are 1. A load of any other index, or a load of index 0 while `cs_on` is 0, does not set it.
- R8: `cs_busy` is 0 in the cycle after `cs_load` with `cs_word` = CS_WORDS-1 (5 by default). It is also released by the first `frame_end` after `tx_on` falls.
- R9: `ud_busy` becomes 1 in the cycle after `tx_on`, `ud_on` and `ud_avail` are all 1. It is 0 in the cycle after `ud_avail` is 0. It is also released by the first `frame_end` after `tx_on` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_on | input | 1 | Transmitter enable |
| cs_on | input | 1 | Channel-status transmit enable |
| ud_on | input | 1 | User-data transmit enable |
| rx_on | input | 1 | Receiver enable |
| frame_end | input | 1 | End-of-frame strobe |
| rx_lock | input | 1 | Receiver locked onto a preamble |
| rx_idle | input | 1 | Incoming stream inactive |
| cs_load | input | 1 | Channel-status word loaded into shifter |
| cs_word | input | $clog2(CS_WORDS) | Index of the loaded channel-status word |
| ud_avail | input | 1 | Transmit user queue holds data |
| tx_busy | output | 1 | Transmit shifter busy |
| rx_busy | output | 1 | Receive shifter busy |
| cs_busy | output | 1 | Channel-status shifting busy |
| ud_busy | output | 1 | User-data activity busy |

## Verification
Three pairs of events can fall in the same cycle. An enable can drop in the cycle that carries `frame_end`, and the bench checks that the flag then survives until a later boundary. An enable can return in the cycle that would complete a pending release, and the bench checks that the flag stays set. A receiver lock can coincide with a stream-inactive pulse, and the bench checks that `rx_busy` stays 0. A sweep varies the distance between the transmit enable falling and the releasing frame boundary. At every step the flag must hold before that boundary and be 0 one cycle after it.

// File: rtl/xcvr_busy_pkg.sv
package xcvr_busy_pkg;

    typedef enum logic [1:0] {
        FLG_TX = 2'd0,
        FLG_RX = 2'd1,
        FLG_CS = 2'd2,
        FLG_UD = 2'd3
    } flag_e;

    localparam int unsigned NUM_FLAGS = 4;

    // Per-tracker request terms produced by the decoder.
    typedef struct packed {
        logic gate;   // controlling enable; low means release pending at frame end
        logic set;    // set event (already qualified by enables)
        logic rel;    // immediate release event
    } flag_req_t;

    typedef struct packed {
        logic busy;
        logic pend;
    } flag_state_t;

    // Shared next-state function of every busy tracker.
    function automatic flag_state_t flag_next(flag_state_t cur, flag_req_t req, logic fe);
        flag_state_t nxt;
        logic        eof_rel;
        eof_rel = cur.pend & fe & ~req.gate;
        if (eof_rel | req.rel) begin
            nxt.busy = 1'b0;
            nxt.pend = 1'b0;
        end else if (req.set) begin
            nxt.busy = 1'b1;
            nxt.pend = 1'b0;
        end else begin
            nxt.busy = cur.busy;
            nxt.pend = cur.busy & ~req.gate;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/xcvr_busy_decode.sv
module xcvr_busy_decode
    import xcvr_busy_pkg::*;
#(
    parameter int unsigned CS_WORDS = 6,
    localparam int unsigned IDX_W   = $clog2(CS_WORDS)
) (
    input  logic                  tx_on,
    input  logic                  cs_on,
    input  logic                  ud_on,
    input  logic                  rx_on,
    input  logic                  rx_lock,
    input  logic                  rx_idle,
    input  logic                  cs_load,
    input  logic [IDX_W-1:0]      cs_word,
    input  logic                  ud_avail,
    output flag_req_t             req [NUM_FLAGS]
);
    localparam logic [IDX_W-1:0] CS_FIRST = '0;
    localparam logic [IDX_W-1:0] CS_LAST  = IDX_W'(CS_WORDS - 1);

    logic cs_first_ld;
    logic cs_last_ld;

    assign cs_first_ld = cs_load & (cs_word == CS_FIRST);
    assign cs_last_ld  = cs_load & (cs_word == CS_LAST);

    always_comb begin
        req[FLG_TX].gate = tx_on;
        req[FLG_TX].set  = tx_on;
        req[FLG_TX].rel  = 1'b0;

        req[FLG_RX].gate = rx_on;
        req[FLG_RX].set  = rx_on & rx_lock;
        req[FLG_RX].rel  = rx_idle;

        req[FLG_CS].gate = tx_on;
        req[FLG_CS].set  = tx_on & cs_on & cs_first_ld;
        req[FLG_CS].rel  = cs_last_ld;

        req[FLG_UD].gate = tx_on;
        req[FLG_UD].set  = tx_on & ud_on & ud_avail;
        req[FLG_UD].rel  = ~ud_avail;
    end
endmodule

// File: rtl/xcvr_busy_flag.sv
module xcvr_busy_flag
    import xcvr_busy_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  flag_req_t req,
    input  logic      frame_end,
    output logic      busy
);
    flag_state_t st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            st <= flag_next(st, req, frame_end);
        end
    end

    assign busy = st.busy;
endmodule

// File: rtl/xcvr_busy_tracker.sv
module xcvr_busy_tracker
    import xcvr_busy_pkg::*;
#(
    parameter int unsigned CS_WORDS = 6,
    localparam int unsigned IDX_W   = $clog2(CS_WORDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_on,
    input  logic             cs_on,
    input  logic             ud_on,
    input  logic             rx_on,
    input  logic             frame_end,
    input  logic             rx_lock,
    input  logic             rx_idle,
    input  logic             cs_load,
    input  logic [IDX_W-1:0] cs_word,
    input  logic             ud_avail,
    output logic             tx_busy,
    output logic             rx_busy,
    output logic             cs_busy,
    output logic             ud_busy
);
    flag_req_t            req [NUM_FLAGS];
    logic [NUM_FLAGS-1:0] busy_vec;

    xcvr_busy_decode #(.CS_WORDS(CS_WORDS)) u_dec (
        .tx_on    (tx_on),
        .cs_on    (cs_on),
        .ud_on    (ud_on),
        .rx_on    (rx_on),
        .rx_lock  (rx_lock),
        .rx_idle  (rx_idle),
        .cs_load  (cs_load),
        .cs_word  (cs_word),
        .ud_avail (ud_avail),
        .req      (req)
    );

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        xcvr_busy_flag u_flag (
            .clk       (clk),
            .rst       (rst),
            .req       (req[g]),
            .frame_end (frame_end),
            .busy      (busy_vec[g])
        );
    end

    assign tx_busy = busy_vec[FLG_TX];
    assign rx_busy = busy_vec[FLG_RX];
    assign cs_busy = busy_vec[FLG_CS];
    assign ud_busy = busy_vec[FLG_UD];
endmodule

// File: rtl/xcvr_busy_tracker_chk.sv
module xcvr_busy_tracker_chk #(
    parameter int unsigned CS_WORDS = 6,
    localparam int unsigned IDX_W   = $clog2(CS_WORDS)
) (
    input logic             clk,
    input logic             rst,
    input logic             tx_on,
    input logic             cs_on,
    input logic             ud_on,
    input logic             rx_on,
    input logic             frame_end,
    input logic             rx_lock,
    input logic             rx_idle,
    input logic             cs_load,
    input logic [IDX_W-1:0] cs_word,
    input logic             ud_avail,
    input logic             tx_busy,
    input logic             rx_busy,
    input logic             cs_busy,
    input logic             ud_busy
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CS_WORDS - 1);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> !(tx_busy | rx_busy | cs_busy | ud_busy));

    // R2
    tx_set_chk: assert property (@(posedge clk) disable iff (rst)
        tx_on |=> tx_busy);

    // R3
    tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_busy && !frame_end) |=> tx_busy);

    // R5
    rx_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (!rx_busy && !(rx_on && rx_lock)) |=> !rx_busy);

    // R6
    rx_idle_chk: assert property (@(posedge clk) disable iff (rst)
        rx_idle |=> !rx_busy);

    // R8
    cs_last_chk: assert property (@(posedge clk) disable iff (rst)
        (cs_load && cs_word == LAST_IDX) |=> !cs_busy);

    // R9
    ud_empty_chk: assert property (@(posedge clk) disable iff (rst)
        !ud_avail |=> !ud_busy);

    // R9
    ud_set_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_on && ud_on && ud_avail) |=> ud_busy);
endmodule

bind xcvr_busy_tracker xcvr_busy_tracker_chk #(.CS_WORDS(CS_WORDS)) u_chk (.*);

// File: tb/tb_xcvr_busy_tracker.sv
`timescale 1ns/1ps
module tb_xcvr_busy_tracker;
    localparam int unsigned CS_WORDS = 6;
    localparam int unsigned IDX_W    = $clog2(CS_WORDS);

    logic clk = 1'b0;
    logic rst;
    logic tx_on, cs_on, ud_on, rx_on;
    logic frame_end, rx_lock, rx_idle, cs_load, ud_avail;
    logic [IDX_W-1:0] cs_word;
    logic tx_busy, rx_busy, cs_busy, ud_busy;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    xcvr_busy_tracker #(.CS_WORDS(CS_WORDS)) dut (
        .clk(clk), .rst(rst),
        .tx_on(tx_on), .cs_on(cs_on), .ud_on(ud_on), .rx_on(rx_on),
        .frame_end(frame_end), .rx_lock(rx_lock), .rx_idle(rx_idle),
        .cs_load(cs_load), .cs_word(cs_word), .ud_avail(ud_avail),
        .tx_busy(tx_busy), .rx_busy(rx_busy), .cs_busy(cs_busy), .ud_busy(ud_busy)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        frame_end = 0; rx_lock = 0; rx_idle = 0; cs_load = 0; cs_word = '0;
    endtask

    task automatic chk(input logic act, input logic exp, input string req);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        tx_on = 0; cs_on = 0; ud_on = 0; rx_on = 0; ud_avail = 0;
        frame_end = 0; rx_lock = 0; rx_idle = 0; cs_load = 0; cs_word = '0;
        rst = 1;
        @(negedge clk);
        tick();
        tick();
        chk(tx_busy, 0, "R1 tx"); chk(rx_busy, 0, "R1 rx");
        chk(cs_busy, 0, "R1 cs"); chk(ud_busy, 0, "R1 ud");
        rst = 0;

        // Transmit flag
        tx_on = 1; tick(); chk(tx_busy, 1, "R2 set");
        frame_end = 1; tick(); chk(tx_busy, 1, "R4 eof while enabled");
        tx_on = 0; frame_end = 1; tick(); chk(tx_busy, 1, "R3 eof in drop cycle");
        tick(); chk(tx_busy, 1, "R3 hold pending");
        frame_end = 1; tick(); chk(tx_busy, 0, "R3 release");
        tx_on = 1; tick(); tx_on = 0; tick(); chk(tx_busy, 1, "R3 pending");
        tx_on = 1; frame_end = 1; tick(); chk(tx_busy, 1, "R4 reassert at eof");
        tx_on = 0; tick();
        tx_on = 1; tick(); tx_on = 0; tick();
        frame_end = 1; tick(); chk(tx_busy, 0, "R4 release after cancel");

        // Sweep distance from drop to releasing boundary
        for (int d = 1; d <= 8; d++) begin
            tx_on = 1; tick();
            tx_on = 0; tick();
            for (int k = 1; k < d; k++) begin
                tick(); chk(tx_busy, 1, "R3 sweep hold");
            end
            frame_end = 1; tick(); chk(tx_busy, 0, "R3 sweep release");
            tick(); chk(tx_busy, 0, "R3 sweep stays idle");
        end

        // Receive flag
        rx_lock = 1; tick(); chk(rx_busy, 0, "R5 lock without enable");
        rx_on = 1; tick(); chk(rx_busy, 0, "R5 enable without lock");
        rx_lock = 1; tick(); chk(rx_busy, 1, "R5 set on lock");
        frame_end = 1; tick(); chk(rx_busy, 1, "R6 eof while enabled");
        rx_idle = 1; tick(); chk(rx_busy, 0, "R6 inactive release");
        rx_lock = 1; rx_idle = 1; tick(); chk(rx_busy, 0, "R6 inactive beats lock");
        rx_lock = 1; tick(); chk(rx_busy, 1, "R5 relock");
        rx_on = 0; tick(); chk(rx_busy, 1, "R6 held after disable");
        frame_end = 1; tick(); chk(rx_busy, 0, "R6 eof release");

        // Channel-status flag
        tx_on = 1; cs_on = 0; cs_load = 1; cs_word = 0; tick();
        chk(cs_busy, 0, "R7 load without cs enable");
        cs_on = 1; cs_load = 1; cs_word = 3; tick();
        chk(cs_busy, 0, "R7 non-first index");
        cs_load = 1; cs_word = 0; tick(); chk(cs_busy, 1, "R7 set on first word");
        for (int w = 1; w < CS_WORDS - 1; w++) begin
            cs_load = 1; cs_word = IDX_W'(w); tick(); chk(cs_busy, 1, "R8 middle word hold");
        end
        cs_load = 1; cs_word = IDX_W'(CS_WORDS - 1); tick();
        chk(cs_busy, 0, "R8 last word release");
        cs_load = 1; cs_word = 0; tick(); chk(cs_busy, 1, "R7 second block");
        tx_on = 0; tick(); chk(cs_busy, 1, "R8 held after tx drop");
        frame_end = 1; tick();
        chk(cs_busy, 0, "R8 eof release"); chk(tx_busy, 0, "R3 eof release with cs");
        cs_on = 0;

        // User-data flag
        tx_on = 1; ud_on = 1; ud_avail = 0; tick(); chk(ud_busy, 0, "R9 empty no set");
        ud_avail = 1; tick(); chk(ud_busy, 1, "R9 set");
        ud_avail = 0; tick(); chk(ud_busy, 0, "R9 empty release");
        ud_avail = 1; tick(); chk(ud_busy, 1, "R9 reset");
        tx_on = 0; tick(); chk(ud_busy, 1, "R9 held after tx drop");
        frame_end = 1; tick(); chk(ud_busy, 0, "R9 eof release");
        tick(); chk(ud_busy, 0, "R9 no set without tx enable");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule